// File: doc/BRIEF.md
# QPSK Symbol Slicer and Two-Stage Frame Validator

This block is the last stage of a packet receiver. It takes equalized QPSK symbols, one per valid cycle, and turns each into two bits from the signs of its I and Q parts. A start-of-frame strobe marks the first symbol of a packet. The block then validates the packet in two steps. First, a checksum guards a length word at the front. That length then sets how many further bits a second checksum covers.

Once the second checksum also passes, the block checks the destination address against the node's own address. It then looks at the frame kind. An accepted data frame raises a one-cycle `dataOk` pulse, and an accepted acknowledgement raises a one-cycle `ackOk` pulse. Any failure drops the packet without a pulse. The block then waits idle for the next start-of-frame.

Wire layout, in time order, with each field MSB first: a 16-bit length word `L`, a 16-bit header checksum, then `L` bits of link unit. The link unit is an 8-bit kind, a 16-bit destination, an optional body, and a 16-bit frame checksum. `L` counts the whole link unit, including its checksum.

Top module: `qpsk_frame_check`

## Requirements
- R1: Each valid symbol yields two bits: the first in time is 1 when I is negative (I MSB set) and 0 otherwise, and the second is 1 when Q is negative and 0 otherwise. A zero component gives 0.
- R2: The 16-bit length word followed by its 16-bit checksum must leave a zero remainder under the CRC (polynomial 0x1021, start value 0xFFFF, MSB first). Otherwise the packet is dropped and the block goes idle.
- R3: A length that is odd, below 40 bits, or above `MAX_LEN` (default 2048) counts as a header failure and drops the packet.
- R4: The frame checksum restarts from 0xFFFF at the first link-unit bit and covers exactly `L` bits. A nonzero remainder drops the packet.
- R5: Only a destination field equal to `myAddr` can produce a pulse.
- R6: A kind field of 0x01 (data) with all checks passed raises `dataOk` for exactly one cycle, in the cycle after the packet's last symbol is accepted.
- R7: A kind field of 0x02 (ack) raises `ackOk` for one cycle only when `L` is 40, meaning an empty body. An ack with a body is dropped.
- R8: Any other kind value is dropped.
- R9: A start-of-frame strobe on a valid symbol always begins a new packet with that symbol, abandoning any packet in progress.
- R10: Cycles with `symValid` low consume no bits and leave the packet state unchanged.
- R11: After reset both pulses are low. The two pulses are never high together, and exactly one pulse is raised per accepted packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Symbol present this cycle |
| sof | input | 1 | Symbol is the first of a packet |
| symI | input | SYM_W | In-phase component, two's complement |
| symQ | input | SYM_W | Quadrature component, two's complement |
| myAddr | input | ADDR_W | This node's address |
| dataOk | output | 1 | One-cycle pulse: data frame accepted |
| ackOk | output | 1 | One-cycle pulse: ack frame accepted |

## Verification
The verdict of one packet and the first symbol of the next can fall in the same cycle. The pulse is registered on the edge that takes the last symbol, while the next packet's start-of-frame symbol can arrive on the very next edge. The bench provokes this by sending packets with no idle cycle between them, including a data frame followed at once by an ack. It judges the outcome by checking each pulse in its exact cycle and confirming that the second packet is still accepted. The same overlap is stressed by random inter-packet spacing, and also by a start-of-frame that cuts a packet short.

// File: rtl/qfc_pkg.sv
package qfc_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef struct packed {
    logic step;      // consume the two bits of this symbol
    logic restart;   // checksum starts from all ones on this symbol
    logic latchLen;  // capture length word
    logic latchMac;  // capture kind and destination
  } qfc_strobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crcStep = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/qfc_datapath.sv
module qfc_datapath
  import qfc_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int LEN_W  = 16,
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qfc_strobe_t       strb,
  input  logic [SYM_W-1:0]  symI,
  input  logic [SYM_W-1:0]  symQ,
  output logic              crcZero,
  output logic [LEN_W-1:0]  lenField,
  output logic [LEN_W-1:0]  lenR,
  output logic [TYPE_W-1:0] typeR,
  output logic [ADDR_W-1:0] destR
);

  localparam int SH_W  = LEN_W + CRC_W;
  localparam int MAC_W = TYPE_W + ADDR_W;

  logic             bitA, bitB;
  logic [CRC_W-1:0] crcR, crcBase, crcNext;
  logic [SH_W-3:0]  shiftR;
  logic [SH_W-1:0]  shNext;

  always_comb begin
    bitA     = symI[SYM_W-1];
    bitB     = symQ[SYM_W-1];
    crcBase  = strb.restart ? '1 : crcR;
    crcNext  = crcStep(crcStep(crcBase, bitA), bitB);
    shNext   = {shiftR, bitA, bitB};
    lenField = shNext[SH_W-1 -: LEN_W];
    crcZero  = (crcNext == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcR   <= '1;
      shiftR <= '0;
      lenR   <= '0;
      typeR  <= '0;
      destR  <= '0;
    end else if (strb.step) begin
      crcR   <= crcNext;
      shiftR <= shNext[SH_W-3:0];
      if (strb.latchLen) lenR <= lenField;
      if (strb.latchMac) {typeR, destR} <= shNext[MAC_W-1:0];
    end
  end

endmodule

// File: rtl/qfc_control.sv
module qfc_control
  import qfc_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int TYPE_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 2048,
  parameter logic [TYPE_W-1:0] TYPE_DATA = 'h01,
  parameter logic [TYPE_W-1:0] TYPE_ACK  = 'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic              sof,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic              crcZero,
  input  logic [LEN_W-1:0]  lenField,
  input  logic [LEN_W-1:0]  lenR,
  input  logic [TYPE_W-1:0] typeR,
  input  logic [ADDR_W-1:0] destR,
  output qfc_strobe_t       strb,
  output logic              dataOk,
  output logic              ackOk
);

  localparam int HDR_SYMS = (LEN_W + CRC_W) / 2;
  localparam int MAC_SYMS = (TYPE_W + ADDR_W) / 2;
  localparam int MIN_LEN  = TYPE_W + ADDR_W + CRC_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY} state_t;

  state_t           state;
  logic [LEN_W-1:0] symCnt, lastIdx;
  logic             startNow, hdrEnd, bodyEnd, lenOk, frameGood;

  always_comb begin
    startNow  = symValid && sof;
    lastIdx   = {1'b0, lenR[LEN_W-1:1]} - LEN_W'(1);
    hdrEnd    = symValid && !sof && state == S_HDR  && symCnt == LEN_W'(HDR_SYMS - 1);
    bodyEnd   = symValid && !sof && state == S_BODY && symCnt == lastIdx;
    lenOk     = !lenField[0] && lenField >= LEN_W'(MIN_LEN) && lenField <= LEN_W'(MAX_LEN);
    frameGood = bodyEnd && crcZero && destR == myAddr;
    strb.step     = symValid;
    strb.restart  = startNow || (symValid && state == S_BODY && symCnt == '0);
    strb.latchLen = hdrEnd;
    strb.latchMac = symValid && !sof && state == S_BODY && symCnt == LEN_W'(MAC_SYMS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      symCnt <= '0;
      dataOk <= 1'b0;
      ackOk  <= 1'b0;
    end else begin
      dataOk <= frameGood && typeR == TYPE_DATA;
      ackOk  <= frameGood && typeR == TYPE_ACK && lenR == LEN_W'(MIN_LEN);
      if (startNow) begin
        state  <= S_HDR;
        symCnt <= LEN_W'(1);
      end else if (symValid) begin
        case (state)
          S_HDR: begin
            if (hdrEnd) begin
              state  <= (crcZero && lenOk) ? S_BODY : S_IDLE;
              symCnt <= '0;
            end else begin
              symCnt <= symCnt + LEN_W'(1);
            end
          end
          S_BODY: begin
            if (bodyEnd) begin
              state  <= S_IDLE;
              symCnt <= '0;
            end else begin
              symCnt <= symCnt + LEN_W'(1);
            end
          end
          default: symCnt <= '0;
        endcase
      end
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(dataOk && ackOk));
  // R6
  data_width_chk: assert property (@(posedge clk) disable iff (!rstN) dataOk |=> !dataOk);
  // R10
  pulse_after_sym_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOk || ackOk) |-> $past(symValid));
  // R7
  ack_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOk |-> $past(lenR) == LEN_W'(MIN_LEN));
  // R3
  body_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BODY && $past(state) == S_HDR) |->
      (!lenR[0] && lenR >= LEN_W'(MIN_LEN) && lenR <= LEN_W'(MAX_LEN)));

endmodule

// File: rtl/qpsk_frame_check.sv
module qpsk_frame_check
  import qfc_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int LEN_W   = 16,
  parameter int TYPE_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 2048,
  parameter logic [TYPE_W-1:0] TYPE_DATA = 'h01,
  parameter logic [TYPE_W-1:0] TYPE_ACK  = 'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic              sof,
  input  logic [SYM_W-1:0]  symI,
  input  logic [SYM_W-1:0]  symQ,
  input  logic [ADDR_W-1:0] myAddr,
  output logic              dataOk,
  output logic              ackOk
);

  qfc_strobe_t       strb;
  logic              crcZero;
  logic [LEN_W-1:0]  lenField, lenR;
  logic [TYPE_W-1:0] typeR;
  logic [ADDR_W-1:0] destR;

  qfc_datapath #(.SYM_W(SYM_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .symI(symI), .symQ(symQ),
    .crcZero(crcZero), .lenField(lenField), .lenR(lenR), .typeR(typeR), .destR(destR)
  );

  qfc_control #(.LEN_W(LEN_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN),
                .TYPE_DATA(TYPE_DATA), .TYPE_ACK(TYPE_ACK)) u_ctl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .sof(sof), .myAddr(myAddr),
    .crcZero(crcZero), .lenField(lenField), .lenR(lenR), .typeR(typeR), .destR(destR),
    .strb(strb), .dataOk(dataOk), .ackOk(ackOk)
  );

endmodule

// File: tb/qpsk_frame_check_bench.sv
`timescale 1ns/1ps
module qpsk_frame_check_bench;

  localparam logic [15:0] ME = 16'hA5C3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic       sof = 1'b0;
  logic [7:0] symI = '0;
  logic [7:0] symQ = '0;
  logic       dataOk, ackOk;

  int total = 0, bad = 0;
  int seenD = 0, seenA = 0, wantD = 0, wantA = 0;
  bit pendOn = 0, pendD = 0, pendA = 0;
  string pendTag;
  bit fr[$];

  always #10 clk = ~clk;

  qpsk_frame_check u_qpsk_frame_check (
    .clk(clk), .rstN(rstN), .symValid(symValid), .sof(sof), .symI(symI), .symQ(symQ),
    .myAddr(ME), .dataOk(dataOk), .ackOk(ackOk)
  );

  always @(negedge clk) if (rstN) begin
    seenD += int'(dataOk);
    seenA += int'(ackOk);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doPending();
    if (pendOn) begin
      check(dataOk == pendD && ackOk == pendA, pendTag,
            {30'd0, dataOk, ackOk}, {30'd0, pendD, pendA});
      pendOn = 0;
    end
  endtask

  task automatic idleCycle();
    @(negedge clk);
    doPending();
    symValid = 1'b0;
    sof = 1'b0;
  endtask

  // R1: sign bit set means bit value 1
  task automatic sendSym(input bit b0, input bit b1, input bit s, input int gapPct);
    while (int'($urandom % 100) < gapPct) idleCycle();
    @(negedge clk);
    doPending();
    symValid = 1'b1;
    sof = s;
    symI = {b0, 7'($urandom)};
    symQ = {b1, 7'($urandom)};
  endtask

  function automatic logic [15:0] crcOf(int from, int upto);
    logic [15:0] c = 16'hFFFF;
    for (int i = from; i < upto; i++) begin
      bit fb = c[15] ^ fr[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic pushBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) fr.push_back(v[i]);
  endtask

  task automatic makeFrame(input logic [7:0] typ, input logic [15:0] dst, input int bodyBits,
                           input bit hdrFlip, input bit fcsFlip, input int lenAdj);
    logic [15:0] len, hc, fc;
    fr.delete();
    len = 16'(40 + bodyBits + lenAdj);
    pushBits(len, 16);
    hc = crcOf(0, 16);
    if (hdrFlip) hc[3] = ~hc[3];
    pushBits(hc, 16);
    pushBits({8'd0, typ}, 8);
    pushBits(dst, 16);
    for (int i = 0; i < bodyBits; i++) fr.push_back(1'($urandom));
    fc = crcOf(32, fr.size());
    pushBits(fc, 16);
    if (fcsFlip) fr[40 + (bodyBits / 2)] = ~fr[40 + (bodyBits / 2)];
  endtask

  task automatic sendFrame(input bit expD, input bit expA, input string tag, input int gapPct);
    for (int i = 0; i < fr.size(); i += 2) sendSym(fr[i], fr[i+1], i == 0, gapPct);
    pendOn = 1; pendD = expD; pendA = expA; pendTag = tag;
    wantD += int'(expD);
    wantA += int'(expA);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!dataOk && !ackOk, "R11 reset pulses low", {30'd0, dataOk, ackOk}, 0);
    rstN = 1'b1;
    idleCycle();

    makeFrame(8'h01, ME, 64, 0, 0, 0);  sendFrame(1, 0, "R6 R1 good data", 0);
    idleCycle();
    makeFrame(8'h02, ME, 0, 0, 0, 0);   sendFrame(0, 1, "R7 good ack", 0);
    idleCycle();
    makeFrame(8'h02, ME, 16, 0, 0, 0);  sendFrame(0, 0, "R7 ack with body dropped", 0);
    idleCycle();
    makeFrame(8'h01, ME, 32, 1, 0, 0);  sendFrame(0, 0, "R2 header crc bad", 0);
    idleCycle();
    makeFrame(8'h01, ME, 64, 0, 0, 4000); sendFrame(0, 0, "R3 length over max", 0);
    idleCycle();
    makeFrame(8'h01, ME, 32, 0, 0, 1);  sendFrame(0, 0, "R3 odd length", 0);
    idleCycle();
    makeFrame(8'h01, ME, 0, 0, 0, -16); sendFrame(0, 0, "R3 length below min", 0);
    idleCycle();
    makeFrame(8'h01, ME, 48, 0, 1, 0);  sendFrame(0, 0, "R4 frame crc bad", 0);
    idleCycle();
    makeFrame(8'h01, ME ^ 16'h0100, 48, 0, 0, 0); sendFrame(0, 0, "R5 address mismatch", 0);
    idleCycle();
    makeFrame(8'h07, ME, 48, 0, 0, 0);  sendFrame(0, 0, "R8 unknown kind", 0);
    idleCycle();
    makeFrame(8'h01, ME, 96, 0, 0, 0);  sendFrame(1, 0, "R10 data with gaps", 60);
    idleCycle();
    // R9: cut a packet short with a new start
    makeFrame(8'h01, ME, 64, 0, 0, 0);
    for (int i = 0; i < 40; i += 2) sendSym(fr[i], fr[i+1], i == 0, 0);
    makeFrame(8'h02, ME, 0, 0, 0, 0);   sendFrame(0, 1, "R9 restart mid packet", 0);
    // back to back, no idle: verdict cycle overlaps next start
    makeFrame(8'h01, ME, 16, 0, 0, 0);  sendFrame(1, 0, "R6 back to back first", 0);
    makeFrame(8'h02, ME, 0, 0, 0, 0);   sendFrame(0, 1, "R7 back to back second", 0);

    for (int n = 0; n < 60; n++) begin
      int k = int'($urandom % 8);
      logic [7:0] typ = (k < 4) ? 8'h01 : (k < 7) ? 8'h02 : 8'h55;
      bit match = ($urandom % 5) != 0;
      int body = (typ == 8'h02 && ($urandom % 4) != 0) ? 0 : 2 * int'($urandom % 100);
      bit hf = ($urandom % 8) == 0;
      bit ff = ($urandom % 8) == 0;
      bit good = match && !hf && !ff;
      makeFrame(typ, match ? ME : 16'h1234, body, hf, ff, 0);
      sendFrame(good && typ == 8'h01, good && typ == 8'h02 && body == 0,
                "R2 R4 R5 R8 random frame", 15);
      repeat (int'($urandom % 3)) idleCycle();
    end
    repeat (3) idleCycle();
    // R11 pulse totals match accepted packets
    check(seenD == wantD, "R11 data pulse count", seenD, wantD);
    check(seenA == wantA, "R11 ack pulse count", seenA, wantA);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule